// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block watches the two ports of a shared RAM, called left and right, and resolves collisions when both of them address the same word at the same time. Each port presents an enable, a valid strobe, a write request and an address. A port counts as active when both its enable and its valid strobe are high. When both ports are active on the same address, the port that was already sitting on that address keeps the word. The other port sees its busy flag rise and loses its write grant until the collision is over. The block is fully synchronous: every input is sampled on the clock edge, and busy and write-grant are registered outputs.

A mode input selects how the busy lines behave. In master mode the block arbitrates on its own and drives the result on its busy outputs. In slave mode its busy outputs stay low, and busy inputs that come from a master device are used instead. Each busy input blocks the write grant of its own port, so several devices can be placed side by side to make a wider word, and all of them follow one arbitration result.

Top module: `dpc_arbiter`

## Requirements
- R1: A port is active when its enable and its valid strobe are both 1. A contention exists only when both ports are active and their addresses are equal. Without a contention no busy flag rises.
- R2: A port arrived first if, on the previous clock, it was already active on the same address it presents now. On a contention the port that arrived first keeps access, and busy goes to the other port only.
- R3: Busy is registered. It rises in the cycle after the first contention cycle. This applies whether the contention began because an address changed onto the other port's word or because the late port's enable went active.
- R4: Busy falls in the cycle after the addresses differ, or after the winning port becomes inactive.
- R5: When both ports arrive in the same cycle, the left port wins and busy goes to the right port. The two busy flags are never high together.
- R6: When the mode input is 1 (master), the busy outputs carry the arbitration result. When it is 0 (slave), both busy outputs are held low.
- R7: In slave mode a port's write grant is 0 in the cycle after a cycle in which that port's busy input was 1. In master mode the busy inputs have no effect.
- R8: A port's write grant is 1 in the cycle after a cycle in which the port is active, requests a write (write bit = 1) and is not blocked. A read (write bit = 0) never gets a grant. The losing port's grant stays 0, and the winner's grant stays 1 for as long as the contention lasts.
- R9: A losing port that holds its request is granted in the cycle after busy clears. If the old winner then returns to the same address, it is the late port and it receives busy.
- R10: Reset is synchronous and active high. In the cycle after reset, every busy output and write-grant output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = master (arbitrate), 0 = slave (follow busy inputs) |
| l_en | input | 1 | Left port enable |
| l_vld | input | 1 | Left port valid strobe |
| l_wr | input | 1 | Left port write request (1 = write) |
| l_addr | input | AW | Left port word address |
| r_en | input | 1 | Right port enable |
| r_vld | input | 1 | Right port valid strobe |
| r_wr | input | 1 | Right port write request (1 = write) |
| r_addr | input | AW | Right port word address |
| l_busy_in | input | 1 | Left busy from an external master (slave mode) |
| r_busy_in | input | 1 | Right busy from an external master (slave mode) |
| l_busy_out | output | 1 | Left port lost the contention (master mode) |
| r_busy_out | output | 1 | Right port lost the contention (master mode) |
| l_wgrant | output | 1 | Left write may take effect |
| r_wgrant | output | 1 | Right write may take effect |

## Verification
Two things can happen in the same cycle: both ports can arrive on the same address together, and one port can move onto the word the other port already holds. The bench provokes the first by releasing both ports from idle onto one address in a single cycle, and it expects the fixed tie rule: right busy, left granted. It provokes the second by parking one port for a cycle and then moving the other port onto that address, once from each side. The outcome is judged by which busy flag rises one cycle later, and by whether the winner's grant survives both the collision and its release.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NSIDE  = 2;
  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
endpackage

// File: rtl/dpca_track.sv
module dpca_track #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          vld,
  input  logic [AW-1:0] addr,
  output logic          act,
  output logic          stay
);
  logic          act_q;
  logic [AW-1:0] addr_q;

  assign act  = en & vld;
  // Port was already parked on this same word last cycle.
  assign stay = act & act_q & (addr == addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q  <= act;
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/dpca_decide.sv
module dpca_decide
  import dpca_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSIDE-1:0]  act,
  input  logic [NSIDE-1:0]  stay,
  input  logic [AW-1:0]     addr_l,
  input  logic [AW-1:0]     addr_r,
  output owner_e            owner_nxt,
  output owner_e            owner_q
);
  logic match;

  assign match = act[SIDE_L] & act[SIDE_R] & (addr_l == addr_r);

  always_comb begin
    owner_nxt = OWN_NONE;
    if (match) begin
      if (owner_q != OWN_NONE)
        owner_nxt = owner_q;
      else if (stay[SIDE_R] && !stay[SIDE_L])
        owner_nxt = OWN_RIGHT;
      else
        owner_nxt = OWN_LEFT;  // left first, or same-cycle tie
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_nxt;
  end

  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (owner_q != OWN_NONE && match) |=> (owner_q == $past(owner_q))); // R2
endmodule

// File: rtl/dpca_grant.sv
module dpca_grant
  import dpca_pkg::*;
#(
  parameter owner_e BEATER = OWN_RIGHT
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   is_master,
  input  logic   act,
  input  logic   wr,
  input  owner_e owner_nxt,
  input  logic   busy_in,
  output logic   busy_out,
  output logic   wgrant
);
  logic lost;
  logic blocked;

  assign lost    = (owner_nxt == BEATER);
  assign blocked = is_master ? lost : busy_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_out <= 1'b0;
      wgrant   <= 1'b0;
    end else begin
      busy_out <= is_master & lost;
      wgrant   <= act & wr & ~blocked;
    end
  end

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !is_master |=> !busy_out); // R6
  AST_SLAVE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!is_master && busy_in) |=> !wgrant); // R7
  AST_LOSER_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    busy_out |-> !wgrant); // R8
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpca_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_master,
  input  logic          l_en,
  input  logic          l_vld,
  input  logic          l_wr,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic          r_vld,
  input  logic          r_wr,
  input  logic [AW-1:0] r_addr,
  input  logic          l_busy_in,
  input  logic          r_busy_in,
  output logic          l_busy_out,
  output logic          r_busy_out,
  output logic          l_wgrant,
  output logic          r_wgrant
);
  logic [NSIDE-1:0]  en_v, vld_v, wr_v, bin_v, bout_v, gnt_v;
  logic [NSIDE-1:0]  act_v, stay_v;
  logic [AW-1:0]     addr_v [NSIDE];
  owner_e            owner_nxt, owner_q;

  assign en_v   = {r_en,  l_en};
  assign vld_v  = {r_vld, l_vld};
  assign wr_v   = {r_wr,  l_wr};
  assign bin_v  = {r_busy_in, l_busy_in};
  assign addr_v[SIDE_L] = l_addr;
  assign addr_v[SIDE_R] = r_addr;

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    localparam owner_e BEATER = (i == SIDE_L) ? OWN_RIGHT : OWN_LEFT;

    dpca_track #(.AW(AW)) u_track (
      .clk  (clk),
      .rst  (rst),
      .en   (en_v[i]),
      .vld  (vld_v[i]),
      .addr (addr_v[i]),
      .act  (act_v[i]),
      .stay (stay_v[i])
    );

    dpca_grant #(.BEATER(BEATER)) u_grant (
      .clk       (clk),
      .rst       (rst),
      .is_master (is_master),
      .act       (act_v[i]),
      .wr        (wr_v[i]),
      .owner_nxt (owner_nxt),
      .busy_in   (bin_v[i]),
      .busy_out  (bout_v[i]),
      .wgrant    (gnt_v[i])
    );
  end

  dpca_decide #(.AW(AW)) u_decide (
    .clk       (clk),
    .rst       (rst),
    .act       (act_v),
    .stay      (stay_v),
    .addr_l    (l_addr),
    .addr_r    (r_addr),
    .owner_nxt (owner_nxt),
    .owner_q   (owner_q)
  );

  assign l_busy_out = bout_v[SIDE_L];
  assign r_busy_out = bout_v[SIDE_R];
  assign l_wgrant   = gnt_v[SIDE_L];
  assign r_wgrant   = gnt_v[SIDE_R];

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(l_busy_out && r_busy_out)); // R5
  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (l_busy_out || r_busy_out) |->
      $past(l_en && l_vld && r_en && r_vld && (l_addr == r_addr))); // R1
  AST_WINNER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (is_master && r_busy_out && l_en && l_vld && l_wr && r_en && r_vld &&
     (l_addr == r_addr)) |=> l_wgrant); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!l_busy_out && !r_busy_out && !l_wgrant && !r_wgrant)); // R10
endmodule

// File: tb/dpc_arbiter_tb.sv
module dpc_arbiter_tb;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b1;
  logic l_en = 0, l_vld = 0, l_wr = 0, r_en = 0, r_vld = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in = 0, r_busy_in = 0;
  logic l_busy_out, r_busy_out, l_wgrant, r_wgrant;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  dpc_arbiter #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .is_master(is_master),
    .l_en(l_en), .l_vld(l_vld), .l_wr(l_wr), .l_addr(l_addr),
    .r_en(r_en), .r_vld(r_vld), .r_wr(r_wr), .r_addr(r_addr),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
    .l_wgrant(l_wgrant), .r_wgrant(r_wgrant)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  // Drive one cycle of port inputs; outputs are sampled after the edge.
  task automatic step(input logic le, input logic lv, input logic lw, input int la,
                      input logic re, input logic rv, input logic rw, input int ra);
    @(negedge clk);
    l_en = le; l_vld = lv; l_wr = lw; l_addr = AW'(la);
    r_en = re; r_vld = rv; r_wr = rw; r_addr = AW'(ra);
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R10", "l_busy_out", l_busy_out, 0);
    chk("R10", "r_busy_out", r_busy_out, 0);
    chk("R10", "l_wgrant", l_wgrant, 0);
    chk("R10", "r_wgrant", r_wgrant, 0);
  endtask

  task automatic t_no_match();
    idle();
    step(1, 1, 1, 10, 1, 1, 1, 11);
    chk("R1", "diff addr l_grant", l_wgrant, 1);
    chk("R1", "diff addr r_grant", r_wgrant, 1);
    chk("R1", "diff addr r_busy", r_busy_out, 0);
    idle();
    step(1, 1, 1, 2, 1, 0, 1, 2);
    chk("R1", "vld low r_busy", r_busy_out, 0);
    chk("R1", "vld low l_busy", l_busy_out, 0);
    chk("R1", "vld low l_grant", l_wgrant, 1);
    chk("R8", "inactive r_grant", r_wgrant, 0);
  endtask

  task automatic t_late_enable();
    idle();
    step(1, 1, 1, 5, 0, 0, 0, 0);
    chk("R8", "lone l_grant", l_wgrant, 1);
    step(1, 1, 1, 5, 1, 1, 1, 5);
    chk("R3", "late en r_busy", r_busy_out, 1);
    chk("R2", "first l_busy", l_busy_out, 0);
    chk("R8", "loser r_grant", r_wgrant, 0);
    chk("R8", "winner l_grant", l_wgrant, 1);
    for (int k = 0; k < 3; k++) begin
      step(1, 1, 1, 5, 1, 1, 1, 5);
      chk("R8", "winner held", l_wgrant, 1);
      chk("R2", "r_busy held", r_busy_out, 1);
    end
    // Release by address mismatch
    step(1, 1, 1, 5, 1, 1, 1, 6);
    chk("R4", "mismatch r_busy", r_busy_out, 0);
    chk("R4", "mismatch r_grant", r_wgrant, 1);
    // Right moves back onto left's word: left stayed, so left wins
    step(1, 1, 1, 5, 1, 1, 1, 5);
    chk("R3", "addr move r_busy", r_busy_out, 1);
    // Winner leaves
    step(0, 1, 1, 5, 1, 1, 1, 5);
    chk("R4", "winner off r_busy", r_busy_out, 0);
    chk("R9", "retry r_grant", r_wgrant, 1);
    chk("R4", "winner off l_grant", l_wgrant, 0);
    // Old winner returns late
    step(1, 1, 1, 5, 1, 1, 1, 5);
    chk("R9", "return l_busy", l_busy_out, 1);
    chk("R9", "return r_busy", r_busy_out, 0);
    chk("R9", "return l_grant", l_wgrant, 0);
    chk("R9", "holder r_grant", r_wgrant, 1);
  endtask

  task automatic t_left_moves();
    idle();
    step(1, 1, 1, 7, 1, 1, 1, 9);
    chk("R1", "apart l_busy", l_busy_out, 0);
    step(1, 1, 1, 9, 1, 1, 1, 9);
    chk("R2", "left moved l_busy", l_busy_out, 1);
    chk("R2", "left moved r_busy", r_busy_out, 0);
    chk("R8", "left moved r_grant", r_wgrant, 1);
    chk("R8", "left moved l_grant", l_wgrant, 0);
  endtask

  task automatic t_tie();
    idle();
    step(1, 1, 1, 3, 1, 1, 1, 3);
    chk("R5", "tie r_busy", r_busy_out, 1);
    chk("R5", "tie l_busy", l_busy_out, 0);
    chk("R5", "tie l_grant", l_wgrant, 1);
    chk("R5", "tie r_grant", r_wgrant, 0);
  endtask

  task automatic t_read();
    idle();
    step(1, 1, 0, 4, 0, 0, 0, 0);
    chk("R8", "read l_grant", l_wgrant, 0);
    step(1, 1, 0, 4, 1, 1, 1, 4);
    chk("R2", "reader wins r_busy", r_busy_out, 1);
    chk("R8", "read loser r_grant", r_wgrant, 0);
    chk("R8", "read winner l_grant", l_wgrant, 0);
  endtask

  task automatic t_slave();
    idle();
    is_master = 0;
    l_busy_in = 1; r_busy_in = 0;
    step(1, 1, 1, 3, 1, 1, 1, 3);
    chk("R6", "slave l_busy_out", l_busy_out, 0);
    chk("R6", "slave r_busy_out", r_busy_out, 0);
    chk("R7", "slave l blocked", l_wgrant, 0);
    chk("R7", "slave r free", r_wgrant, 1);
    @(negedge clk);
    l_busy_in = 0; r_busy_in = 1;
    step(1, 1, 1, 3, 1, 1, 1, 3);
    chk("R7", "slave l free", l_wgrant, 1);
    chk("R7", "slave r blocked", r_wgrant, 0);
    idle();
    is_master = 1;
    step(1, 1, 1, 1, 1, 1, 1, 8);
    chk("R7", "master ignores l_busy_in", l_wgrant, 1);
    chk("R7", "master ignores r_busy_in", r_wgrant, 1);
    l_busy_in = 0; r_busy_in = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 0;
    t_no_match();
    t_late_enable();
    t_left_moves();
    t_tie();
    t_read();
    t_slave();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule